// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates seven interrupt request lines for a small 8-bit CPU core. Each line has its own enable bit, and a global enable masks all of them at once. Six of the lines can each be given one of four priority levels. The seventh line, the comparator line, always sits at the lowest level. When the core signals an instruction boundary, the controller picks the winning pending request. It then presents that request's vector index and holds it until the core acknowledges it.

Acknowledged levels are recorded in an in-service mask with one bit per level. The mask enforces strict nesting: a new request is offered only if its level is strictly above the highest level already in service. A return strobe from the core removes the innermost (highest) in-service level. Software configures the enable register and the two priority-bit registers through a plain write/read port with one cycle of read latency.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous reset, the following are all zero: the enable register, both priority-bit registers, `irq_valid`, `irq_vector`, `irq_level`, `in_service` and `reg_rdata`.
- R2: A write with `reg_wr` high stores `reg_wdata` into the register chosen by `reg_sel`. Selector 0 is the enable register: bit 7 is the global enable and bit i enables source i. Selector 1 holds the low priority bits and selector 2 holds the high priority bits, bits 5:0 each, for sources 0..5. Bits 7:6 of both priority registers read as zero. Selector 3 reads zero and ignores writes. `reg_rdata` shows the selected register one cycle after `reg_sel`, and the value it shows is the one from before any write made in that same cycle.
- R3: While the global enable bit is 0, no request is ever offered.
- R4: A source whose own enable bit is 0 is never offered.
- R5: The effective level of source i (i<6) is 2·high[i] + low[i], so level 3 is the highest. Among the eligible requests, the one with the highest level wins.
- R6: Source 6 (the comparator) always has level 0, whatever is written to the priority registers.
- R7: Among eligible requests of equal level, the lowest source index wins. The polling order is: external 0 (0), timer 0 (1), external 1 (2), timer 1 (3), serial (4), general-purpose (5), comparator (6).
- R8: Arbitration happens only on a cycle with `boundary` high while no request is being offered. The result appears on the next cycle as `irq_valid`=1, `irq_vector`=source+1 (vector 0 is reserved for reset) and `irq_level`. These outputs stay unchanged until `irq_ack`. While `irq_valid` is 0, `irq_vector` and `irq_level` are 0.
- R9: `irq_ack` while `irq_valid` is high sets `in_service[irq_level]` and clears `irq_valid` on the next cycle. `irq_ack` while `irq_valid` is low has no effect.
- R10: A request is eligible only if `in_service` is zero or its level is strictly greater than the highest set bit of `in_service`. While level 3 is in service, nothing is offered.
- R11: `reti` clears the highest set bit of `in_service`. It has no effect when the mask is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 7 | Level request per source, index = polling order |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| irq_ack | input | 1 | Core accepts the offered request |
| reti | input | 1 | Return-from-interrupt strobe |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 2 | Register selector (0 enable, 1 low prio, 2 high prio) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| irq_valid | output | 1 | A request is being offered |
| irq_vector | output | 3 | Vector index of the offered request (source+1) |
| irq_level | output | 2 | Level of the offered request |
| in_service | output | 4 | In-service mask, one bit per level |

## Verification
Several rules are checked by assertions on every cycle. An offered vector stays stable until it is acknowledged. An acknowledge records the offered level and drops the offer. Every offer lies strictly above the in-service ceiling. No offer appears while the global enable is off. A return removes exactly one in-service bit. The comparator is never offered above level 0. Only the bench scenarios can show that the right source wins: among mixed levels, among ties, against individual masks and across a full nest-and-unwind sequence. They also cover the register read-back values and the fact that nothing is offered between boundary strobes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = 2;
  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [NUM_LVL-1:0] lvl_mask_t;

  // index of the highest set bit of an in-service mask (0 when empty)
  function automatic lvl_t top_of(input lvl_mask_t m);
    lvl_t t;
    t = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (m[i]) t = lvl_t'(i);
    return t;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int N_SRC = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             glb_en,
  output logic [N_SRC-1:0] src_en,
  output logic [N_SRC-1:0] prio_lo,
  output logic [N_SRC-1:0] prio_hi
);
  localparam int NP = N_SRC - 1;  // programmable sources

  logic [N_SRC:0] en_q;
  logic [NP-1:0]  lo_q, hi_q;
  logic [DW-1:0]  rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr) begin
      case (sel)
        2'd0:    en_q <= wdata[N_SRC:0];
        2'd1:    lo_q <= wdata[NP-1:0];
        2'd2:    hi_q <= wdata[NP-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      2'd0:    rd_mux = DW'(en_q);
      2'd1:    rd_mux = DW'(lo_q);
      2'd2:    rd_mux = DW'(hi_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign glb_en  = en_q[N_SRC];
  assign src_en  = en_q[N_SRC-1:0];
  // last source has no priority bits: fixed lowest level
  assign prio_lo = {1'b0, lo_q};
  assign prio_hi = {1'b0, hi_q};
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 7,
  parameter int IW    = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req,
  input  logic             glb_en,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] prio_lo,
  input  logic [N_SRC-1:0] prio_hi,
  input  logic             busy,
  input  lvl_t             ceiling,
  output logic             hit,
  output logic [IW-1:0]    win_idx,
  output lvl_t             win_lvl
);
  logic [N_SRC-1:0] elig;
  lvl_t             lvl [N_SRC];

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign lvl[i]  = {prio_hi[i], prio_lo[i]};
    assign elig[i] = req[i] && src_en[i] && glb_en &&
                     (!busy || (lvl[i] > ceiling));
  end

  // scan from the last index down; ">=" lets a lower index take equal levels
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (!hit || lvl[i] >= win_lvl)) begin
        hit     = 1'b1;
        win_idx = IW'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_en,
  input  lvl_t      set_lvl,
  input  logic      pop,
  output lvl_mask_t isr,
  output logic      busy,
  output lvl_t      ceiling
);
  lvl_mask_t popped;

  always_comb begin
    popped = isr;
    if (pop && busy) popped[top_of(isr)] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)         isr <= '0;
    else if (set_en) isr <= popped | (lvl_mask_t'(1) << set_lvl);
    else             isr <= popped;
  end

  assign busy    = |isr;
  assign ceiling = top_of(isr);

  // R11
  pop_one_chk: assert property (@(posedge clk) disable iff (rst)
    pop && !set_en && busy |=> $countones(isr) == $countones($past(isr)) - 1);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = 7,
  parameter int DW    = 8,
  parameter int VW    = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             boundary,
  input  logic             irq_ack,
  input  logic             reti,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq_valid,
  output logic [VW-1:0]    irq_vector,
  output logic [LVL_W-1:0] irq_level,
  output logic [NUM_LVL-1:0] in_service
);
  localparam int IW = $clog2(N_SRC);

  logic             glb_en, busy, hit;
  logic [N_SRC-1:0] src_en, prio_lo, prio_hi;
  logic [IW-1:0]    win_idx;
  lvl_t             win_lvl, ceiling;
  logic             take;

  irq_regs #(.N_SRC(N_SRC), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .glb_en(glb_en), .src_en(src_en),
    .prio_lo(prio_lo), .prio_hi(prio_hi)
  );

  irq_arbiter #(.N_SRC(N_SRC), .IW(IW)) u_arb (
    .req(irq_req), .glb_en(glb_en), .src_en(src_en),
    .prio_lo(prio_lo), .prio_hi(prio_hi), .busy(busy), .ceiling(ceiling),
    .hit(hit), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign take = irq_valid && irq_ack;

  irq_nest u_nest (
    .clk(clk), .rst(rst), .set_en(take), .set_lvl(irq_level),
    .pop(reti), .isr(in_service), .busy(busy), .ceiling(ceiling)
  );

  always_ff @(posedge clk) begin
    if (rst || take) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_level  <= '0;
    end else if (!irq_valid && boundary && hit) begin
      irq_valid  <= 1'b1;
      irq_vector <= VW'(win_idx) + VW'(1);
      irq_level  <= win_lvl;
    end
  end

  // R8
  hold_vec_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_vector) && $stable(irq_level));
  // R8
  no_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_valid && !boundary |=> !irq_valid);
  // R9
  ack_record_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid && irq_ack |=> !irq_valid && in_service[$past(irq_level)]);
  // R10
  above_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid && busy |-> irq_level > ceiling);
  // R3
  global_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> $past(glb_en));
  // R6
  cmp_low_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid && irq_vector == VW'(N_SRC) |-> irq_level == '0);
endmodule

// File: tb/tb_irq_nest_ctrl.sv
`timescale 1ns/1ps
module tb_irq_nest_ctrl;
  logic       clk = 0, rst = 1;
  logic [6:0] irq_req = 0;
  logic       boundary = 0, irq_ack = 0, reti = 0, reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       irq_valid;
  logic [2:0] irq_vector;
  logic [1:0] irq_level;
  logic [3:0] in_service;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_nest_ctrl dut (.*);

  // behavioural reference model
  int m_en, m_lo, m_hi, m_isr, m_valid, m_vec, m_lvl, m_rd;

  function automatic int lvl_of(int s);
    if (s == 6) return 0;
    return ((m_hi >> s) & 1) * 2 + ((m_lo >> s) & 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_lo = 0; m_hi = 0; m_isr = 0;
      m_valid = 0; m_vec = 0; m_lvl = 0; m_rd = 0;
    end else begin
      int nisr, top, pick;
      m_rd = (reg_sel == 0) ? m_en : (reg_sel == 1) ? m_lo :
             (reg_sel == 2) ? m_hi : 0;
      top = -1;
      for (int l = 0; l < 4; l++) if ((m_isr >> l) & 1) top = l;
      nisr = m_isr;
      if (reti && top >= 0) nisr = nisr & ~(1 << top);
      if (m_valid && irq_ack) begin
        nisr = nisr | (1 << m_lvl);
        m_valid = 0; m_vec = 0; m_lvl = 0;
      end else if (!m_valid && boundary && ((m_en >> 7) & 1)) begin
        pick = -1;
        for (int l = 3; l >= 0 && pick < 0; l--)
          if (l > top)
            for (int s = 0; s < 7 && pick < 0; s++)
              if (irq_req[s] && ((m_en >> s) & 1) && lvl_of(s) == l) pick = s;
        if (pick >= 0) begin
          m_valid = 1; m_vec = pick + 1; m_lvl = lvl_of(pick);
        end
      end
      m_isr = nisr;
      if (reg_wr)
        case (reg_sel)
          0: m_en = reg_wdata;
          1: m_lo = reg_wdata & 8'h3F;
          2: m_hi = reg_wdata & 8'h3F;
          default: ;
        endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (!rst) begin
    chk(reg_rdata == m_rd[7:0], "R2 model rdata", reg_rdata, m_rd);
    chk(irq_valid == m_valid[0], "R8 model valid", irq_valid, m_valid);
    chk(irq_vector == m_vec[2:0], "R7 model vector", irq_vector, m_vec);
    chk(irq_level == m_lvl[1:0], "R5 model level", irq_level, m_lvl);
    chk(in_service == m_isr[3:0], "R9 model in_service", in_service, m_isr);
  end

  task automatic wr(input int sel, input int d);
    @(negedge clk); reg_wr = 1; reg_sel = 2'(sel); reg_wdata = 8'(d);
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input int sel, input int exp, input string tag);
    @(negedge clk); reg_sel = 2'(sel);
    @(negedge clk); chk(reg_rdata == 8'(exp), tag, reg_rdata, exp);
  endtask
  task automatic bnd();
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
  endtask
  task automatic ack_t();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask
  task automatic reti_t();
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
  endtask
  task automatic offer(input int vec, input int lvl, input string tag);
    chk(irq_valid && irq_vector == 3'(vec) && irq_level == 2'(lvl), tag,
        {irq_valid, irq_vector, irq_level}, {1'b1, 3'(vec), 2'(lvl)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!irq_valid && irq_vector == 0 && irq_level == 0, "R1 outputs", irq_valid, 0);
    chk(in_service == 0 && reg_rdata == 0, "R1 mask/rdata", in_service, 0);
    rd(0, 0, "R1 enable reg"); rd(1, 0, "R1 low reg"); rd(2, 0, "R1 high reg");

    // R3 global off masks everything
    wr(0, 8'h7F); irq_req = 7'h7F; bnd(); @(negedge clk);
    chk(!irq_valid, "R3 global off", irq_valid, 0);

    // R2 register map
    wr(1, 8'hFF); rd(1, 8'h3F, "R2 low bits 7:6 zero");
    wr(2, 8'hFF); rd(2, 8'h3F, "R2 high bits 7:6 zero");
    wr(3, 8'hFF); rd(3, 0, "R2 selector 3 reads zero");
    rd(0, 8'h7F, "R2 enable readback");

    // R4 + R6: only comparator enabled, all priority bits set
    wr(0, 8'hC0); bnd();
    offer(7, 0, "R6 comparator at level 0");
    ack_t(); chk(in_service == 4'b0001, "R9 level0 recorded", in_service, 1);
    reti_t(); chk(in_service == 0, "R11 pop to empty", in_service, 0);
    wr(0, 8'h80); bnd();
    chk(!irq_valid, "R4 all sources masked", irq_valid, 0);

    // R7 tie order
    wr(0, 8'hFF); wr(1, 0); wr(2, 0);
    irq_req = 7'h60; bnd();
    offer(6, 0, "R7 general-purpose before comparator");
    ack_t(); reti_t();
    irq_req = 7'h7F; bnd();
    offer(1, 0, "R7 external 0 first");
    ack_t(); reti_t();

    // R5 levels: serial level 1, timer 0 level 2
    wr(1, 8'h10); wr(2, 8'h02); bnd();
    offer(2, 2, "R5 highest level wins");
    // R8 held while unacknowledged
    irq_req = 0; bnd(); repeat (2) @(negedge clk);
    offer(2, 2, "R8 vector held");
    ack_t(); chk(!irq_valid && in_service == 4'b0100, "R9 ack records level2",
                 in_service, 4'b0100);
    ack_t(); chk(in_service == 4'b0100, "R9 stray ack ignored", in_service, 4'b0100);

    // R10 lower and equal levels blocked
    irq_req = 7'h10; bnd(); @(negedge clk);
    chk(!irq_valid, "R10 lower level blocked", irq_valid, 0);
    wr(2, 8'h0A); irq_req = 7'h08; bnd(); @(negedge clk);
    chk(!irq_valid, "R10 equal level blocked", irq_valid, 0);
    // ext1 to level 3 preempts
    wr(1, 8'h14); wr(2, 8'h0E); irq_req = 7'h7F; bnd();
    offer(3, 3, "R10 higher level preempts");
    ack_t(); chk(in_service == 4'b1100, "R9 nested mask", in_service, 4'b1100);
    bnd(); @(negedge clk);
    chk(!irq_valid, "R10 top level never preempted", irq_valid, 0);
    reti_t(); chk(in_service == 4'b0100, "R11 pops highest", in_service, 4'b0100);
    reti_t(); chk(in_service == 0, "R11 pops last", in_service, 0);
    reti_t(); chk(in_service == 0, "R11 empty pop ignored", in_service, 0);

    // R8 no arbitration without boundary
    repeat (4) @(negedge clk);
    chk(!irq_valid, "R8 idle without boundary", irq_valid, 0);
    bnd(); offer(3, 3, "R8 arbitration on boundary");
    ack_t(); reti_t();
    irq_req = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule